// File: doc/BRIEF.md
# Two-Dimensional Parity Encoder and Corrector

This block guards a 16-bit word with row and column parity. The word is laid out as a 4x4 bit grid. Each grid row gets one parity bit, and a fifth row of check bits is added below, one bit per column. The bit in the corner of that fifth row covers the column of row-parity bits. This gives a 25-bit code word. A single mode input selects even or odd parity, and that choice applies to every row and every column.

The encoder output is available at once as a 25-bit parallel word. It can also be loaded into a transmit shifter that sends the word one bit per clock. The decoder takes a code word in one of two ways: loaded in parallel, or assembled from a valid-qualified serial input.

The decoder computes a syndrome for each row and for each column. When exactly one row fails and exactly one column fails, it inverts the bit where they cross. It then removes the parity bits and returns the 16 data bits together with a 2-bit status. The status tells four cases apart: no error, a corrected data bit, a fault confined to a parity bit, and an uncorrectable pattern.

Top module: `grid_par_codec`

## Requirements
- R1: Data bit `enc_data_i[15]` is the top-left grid cell, and the data fills the grid row by row. Code word bits are numbered so that bit 24 is sent first. Grid row r, column c sits at code word bit 24-(5r+c). Column 4 of rows 0 to 3 holds the row parity bit.
- R2: Row 4 of the grid is the check row. Each of its bits sets the parity of its own column, and the corner bit (code word bit 0) covers the row-parity column. Example: with even parity, data 16'b0010111101011011 encodes to 25'b0010111110010101011100110.
- R3: With `odd_i`=0, every row and every column holds an even number of ones. With `odd_i`=1, every row and every column holds an odd number of ones. The setting applies to encoding and decoding alike.
- R4: A one-cycle `tx_load_i` captures the current `enc_cw_o`. For the next 25 cycles, `tx_valid_o` is high and `tx_bit_o` presents code word bits 24 down to 0, one per cycle. After that, `tx_valid_o` returns low.
- R5: The receive shifter takes `rx_bit_i` only in cycles where `rx_valid_i` is high. The first accepted bit becomes code word bit 24. `rx_done_o` pulses for one cycle in the cycle after the 25th accepted bit. The decoded result appears on `dec_valid_o` in the cycle after that.
- R6: A one-cycle `dec_load_i` with `dec_cw_i` produces a one-cycle `dec_valid_o` in the next cycle, with `dec_data_o` and `dec_status_o` for that word.
- R7: A code word whose rows and columns all pass gives status 0 (clean), and `dec_data_o` holds the 16 data cells in row order.
- R8: When exactly one data row (0 to 3) fails and exactly one data column (0 to 3) fails, the bit where they cross is inverted. The output data is the corrected data, and the status is 1 (corrected).
- R9: When exactly one row and one column fail and they cross at a parity cell (column 4 or row 4), the status is 2 (parity only), and the data is the received data cells unchanged.
- R10: Any other syndrome pattern (two or more failing rows or columns, or a row failure without a column failure, or the reverse) gives status 3 (uncorrectable). The data is then the received data cells with no bit inverted.
- R11: While reset is asserted, and after it is released, `tx_valid_o`, `rx_done_o` and `dec_valid_o` are low and `dec_status_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| odd_i | input | 1 | Parity sense: 0 even, 1 odd |
| enc_data_i | input | 16 | Data word to encode |
| enc_cw_o | output | 25 | Encoded code word, combinational |
| tx_load_i | input | 1 | Load the encoded word into the transmit shifter |
| tx_bit_o | output | 1 | Serial code word bit |
| tx_valid_o | output | 1 | High while `tx_bit_o` carries a code word bit |
| rx_valid_i | input | 1 | Qualifies `rx_bit_i` |
| rx_bit_i | input | 1 | Serial received bit |
| rx_done_o | output | 1 | Pulse after the 25th accepted serial bit |
| dec_load_i | input | 1 | Decode `dec_cw_i` |
| dec_cw_i | input | 25 | Parallel received code word |
| dec_valid_o | output | 1 | Decode result valid |
| dec_data_o | output | 16 | Recovered data |
| dec_status_o | output | 2 | 0 clean, 1 corrected, 2 parity only, 3 uncorrectable |

## Verification
The encoder is checked against the worked example and against several other data words in both parity senses. Comparing the two senses shows whether the selected sense reaches every row and column, including the corner.

Each data cell of one word is corrupted in turn. This shows whether the crossing point is located correctly, as opposed to the bit merely being flagged. Each parity cell is also corrupted in turn, which separates a parity-only fault from a corrected data bit.

Double errors are applied in two arrangements: two errors in the same row, and two errors in different rows and columns. The bench confirms that both give status 3 and leave the data uncorrected. The serial paths are tried in two ways, as a direct loopback and with gaps in the receive valid signal. These show that the bit order is right and that only qualified bits are counted.

// File: rtl/grid_par_pkg.sv
package grid_par_pkg;
  typedef enum logic [1:0] {
    ST_CLEAN  = 2'd0,
    ST_FIXED  = 2'd1,
    ST_PARITY = 2'd2,
    ST_FATAL  = 2'd3
  } dec_status_e;
endpackage

// File: rtl/grid_par_enc.sv
module grid_par_enc #(
  parameter int ROWS = 4,
  parameter int COLS = 4,
  localparam int DW = ROWS * COLS,
  localparam int CW = (ROWS + 1) * (COLS + 1)
) (
  input  logic [DW-1:0] data_i,
  input  logic          odd_i,
  output logic [CW-1:0] cw_o
);
  logic [COLS:0] col_par;
  logic          row_par;

  always_comb begin
    cw_o    = '0;
    col_par = {(COLS+1){odd_i}};
    for (int r = 0; r < ROWS; r++) begin
      row_par = odd_i;
      for (int c = 0; c < COLS; c++) begin
        cw_o[CW-1-(r*(COLS+1)+c)] = data_i[DW-1-(r*COLS+c)];
        row_par    ^= data_i[DW-1-(r*COLS+c)];
        col_par[c] ^= data_i[DW-1-(r*COLS+c)];
      end
      cw_o[CW-1-(r*(COLS+1)+COLS)] = row_par;
      col_par[COLS] ^= row_par;
    end
    for (int c = 0; c <= COLS; c++)
      cw_o[CW-1-(ROWS*(COLS+1)+c)] = col_par[c];
  end
endmodule

// File: rtl/grid_par_dec.sv
module grid_par_dec
  import grid_par_pkg::*;
#(
  parameter int ROWS = 4,
  parameter int COLS = 4,
  localparam int DW = ROWS * COLS,
  localparam int CW = (ROWS + 1) * (COLS + 1)
) (
  input  logic [CW-1:0] cw_i,
  input  logic          odd_i,
  output logic [DW-1:0] data_o,
  output dec_status_e   status_o
);
  logic [ROWS:0] row_fail;
  logic [COLS:0] col_fail;
  logic [CW-1:0] flip, fixed;
  logic [DW-1:0] raw_data;
  int            err_r, err_c;
  logic          single;

  always_comb begin
    row_fail = {(ROWS+1){odd_i}};
    col_fail = {(COLS+1){odd_i}};
    for (int r = 0; r <= ROWS; r++)
      for (int c = 0; c <= COLS; c++) begin
        row_fail[r] ^= cw_i[CW-1-(r*(COLS+1)+c)];
        col_fail[c] ^= cw_i[CW-1-(r*(COLS+1)+c)];
      end
    err_r = 0;
    err_c = 0;
    for (int r = 0; r <= ROWS; r++) if (row_fail[r]) err_r = r;
    for (int c = 0; c <= COLS; c++) if (col_fail[c]) err_c = c;
    single = ($countones(row_fail) == 1) && ($countones(col_fail) == 1);
    flip = '0;
    if (single) flip[CW-1-(err_r*(COLS+1)+err_c)] = 1'b1;
    fixed = cw_i ^ flip;
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) begin
        data_o[DW-1-(r*COLS+c)]   = fixed[CW-1-(r*(COLS+1)+c)];
        raw_data[DW-1-(r*COLS+c)] = cw_i[CW-1-(r*(COLS+1)+c)];
      end
    if (row_fail == '0 && col_fail == '0) status_o = ST_CLEAN;
    else if (!single)                     status_o = ST_FATAL;
    else if (err_r < ROWS && err_c < COLS) status_o = ST_FIXED;
    else                                   status_o = ST_PARITY;
  end

  always_comb begin
    // R8
    if (status_o == ST_FIXED)
      fixed_one_bit_chk: assert ($countones(data_o ^ raw_data) == 1);
    // R10
    if (status_o != ST_FIXED)
      raw_data_kept_chk: assert (data_o == raw_data);
  end
endmodule

// File: rtl/grid_par_ser.sv
module grid_par_ser #(
  parameter int CW = 25,
  localparam int CNT_W = $clog2(CW + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] cw_i,
  output logic          bit_o,
  output logic          valid_o
);
  logic [CW-1:0]    sreg;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sreg <= '0;
      cnt  <= '0;
    end else if (load_i) begin
      sreg <= cw_i;
      cnt  <= CNT_W'(CW);
    end else if (cnt != '0) begin
      sreg <= {sreg[CW-2:0], 1'b0};
      cnt  <= cnt - 1'b1;
    end
  end

  assign bit_o   = sreg[CW-1];
  assign valid_o = (cnt != '0);

  // R4
  tx_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> valid_o);
  // R4
  tx_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_o && !load_i) |=> !valid_o);
endmodule

// File: rtl/grid_par_deser.sv
module grid_par_deser #(
  parameter int CW = 25,
  localparam int CNT_W = $clog2(CW)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic          bit_i,
  output logic [CW-1:0] cw_o,
  output logic          done_o
);
  logic [CW-2:0]    sreg;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sreg   <= '0;
      cnt    <= '0;
      cw_o   <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (valid_i) begin
        sreg <= {sreg[CW-3:0], bit_i};
        if (cnt == CNT_W'(CW - 1)) begin
          cw_o   <= {sreg, bit_i};
          done_o <= 1'b1;
          cnt    <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R5
  rx_done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R5
  rx_done_qual_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !done_o);
endmodule

// File: rtl/grid_par_codec.sv
module grid_par_codec
  import grid_par_pkg::*;
#(
  parameter int ROWS = 4,
  parameter int COLS = 4,
  localparam int DW = ROWS * COLS,
  localparam int CW = (ROWS + 1) * (COLS + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          odd_i,
  input  logic [DW-1:0] enc_data_i,
  output logic [CW-1:0] enc_cw_o,
  input  logic          tx_load_i,
  output logic          tx_bit_o,
  output logic          tx_valid_o,
  input  logic          rx_valid_i,
  input  logic          rx_bit_i,
  output logic          rx_done_o,
  input  logic          dec_load_i,
  input  logic [CW-1:0] dec_cw_i,
  output logic          dec_valid_o,
  output logic [DW-1:0] dec_data_o,
  output logic [1:0]    dec_status_o
);
  logic [CW-1:0] rx_cw, dec_src;
  logic [DW-1:0] dec_data;
  dec_status_e   dec_status;

  grid_par_enc #(.ROWS(ROWS), .COLS(COLS)) i_enc (
    .data_i(enc_data_i), .odd_i(odd_i), .cw_o(enc_cw_o));

  grid_par_ser #(.CW(CW)) i_ser (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(tx_load_i), .cw_i(enc_cw_o),
    .bit_o(tx_bit_o), .valid_o(tx_valid_o));

  grid_par_deser #(.CW(CW)) i_deser (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(rx_valid_i), .bit_i(rx_bit_i),
    .cw_o(rx_cw), .done_o(rx_done_o));

  // parallel load wins a same-cycle collision
  assign dec_src = dec_load_i ? dec_cw_i : rx_cw;

  grid_par_dec #(.ROWS(ROWS), .COLS(COLS)) i_dec (
    .cw_i(dec_src), .odd_i(odd_i), .data_o(dec_data), .status_o(dec_status));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dec_valid_o  <= 1'b0;
      dec_data_o   <= '0;
      dec_status_o <= ST_CLEAN;
    end else begin
      dec_valid_o <= dec_load_i | rx_done_o;
      if (dec_load_i | rx_done_o) begin
        dec_data_o   <= dec_data;
        dec_status_o <= dec_status;
      end
    end
  end

  // R6
  dec_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_load_i |=> dec_valid_o);
  // R5
  rx_to_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_done_o |=> dec_valid_o);
  // R6
  dec_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dec_load_i && !rx_done_o) |=> !dec_valid_o);
endmodule

// File: tb/test_grid_par_codec.sv
`timescale 1ns/1ps
module test_grid_par_codec;
  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        odd = 1'b0;
  logic [15:0] enc_data = '0;
  logic [24:0] enc_cw;
  logic        tx_load = 1'b0, tx_bit, tx_valid;
  logic        drv_valid = 1'b0, drv_bit = 1'b0, lp = 1'b0;
  logic        rx_valid, rx_bit, rx_done;
  logic        dec_load = 1'b0;
  logic [24:0] dec_cw = '0;
  logic        dec_valid;
  logic [15:0] dec_data;
  logic [1:0]  dec_status;

  int n_chk = 0, n_fail = 0;
  logic [15:0] q_data[$];
  logic [1:0]  q_st[$];
  string       q_tag[$];

  always #4 clk = ~clk;

  assign rx_valid = lp ? tx_valid : drv_valid;
  assign rx_bit   = lp ? tx_bit   : drv_bit;

  grid_par_codec i_grid_par_codec (
    .clk_i(clk), .rst_ni(rst_ni), .odd_i(odd), .enc_data_i(enc_data),
    .enc_cw_o(enc_cw), .tx_load_i(tx_load), .tx_bit_o(tx_bit),
    .tx_valid_o(tx_valid), .rx_valid_i(rx_valid), .rx_bit_i(rx_bit),
    .rx_done_o(rx_done), .dec_load_i(dec_load), .dec_cw_i(dec_cw),
    .dec_valid_o(dec_valid), .dec_data_o(dec_data), .dec_status_o(dec_status));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [24:0] ref_enc(input logic [15:0] d, input logic o);
    logic g[5][5];
    logic [24:0] w;
    for (int r = 0; r < 5; r++) for (int c = 0; c < 5; c++) g[r][c] = 1'b0;
    for (int r = 0; r < 4; r++) for (int c = 0; c < 4; c++) g[r][c] = d[15-4*r-c];
    for (int r = 0; r < 4; r++) begin
      g[r][4] = o;
      for (int c = 0; c < 4; c++) g[r][4] ^= g[r][c];
    end
    for (int c = 0; c < 5; c++) begin
      g[4][c] = o;
      for (int r = 0; r < 4; r++) g[4][c] ^= g[r][c];
    end
    for (int r = 0; r < 5; r++) for (int c = 0; c < 5; c++) w[24-5*r-c] = g[r][c];
    return w;
  endfunction

  function automatic logic [15:0] strip(input logic [24:0] w);
    logic [15:0] d;
    for (int r = 0; r < 4; r++) for (int c = 0; c < 4; c++) d[15-4*r-c] = w[24-5*r-c];
    return d;
  endfunction

  // monitor: pop expectations as results appear
  always @(negedge clk) begin
    if (rst_ni && dec_valid) begin
      if (q_data.size() == 0) chk(1'b0, "R6 unexpected dec_valid", 1, 0);
      else begin
        logic [15:0] ed; logic [1:0] es; string t;
        ed = q_data.pop_front(); es = q_st.pop_front(); t = q_tag.pop_front();
        chk(dec_data == ed, {t, " data"}, dec_data, ed);
        chk(dec_status == es, {t, " status"}, dec_status, es);
      end
    end
  end

  task automatic par_dec(input logic [24:0] w, input logic o, input logic [15:0] ed,
                         input logic [1:0] es, input string t);
    @(negedge clk);
    odd = o; dec_cw = w; dec_load = 1'b1;
    q_data.push_back(ed); q_st.push_back(es); q_tag.push_back(t);
    @(negedge clk);
    dec_load = 1'b0;
  endtask

  task automatic enc_chk(input logic [15:0] d, input logic o, input string t);
    @(negedge clk);
    odd = o; enc_data = d;
    #1;
    chk(enc_cw == ref_enc(d, o), t, enc_cw, ref_enc(d, o));
  endtask

  task automatic ser_loop(input logic [15:0] d, input logic o);
    logic [24:0] w;
    w = ref_enc(d, o);
    @(negedge clk);
    lp = 1'b1; odd = o; enc_data = d; tx_load = 1'b1;
    q_data.push_back(d); q_st.push_back(2'd0); q_tag.push_back("R5 loopback R7");
    @(negedge clk);
    tx_load = 1'b0;
    for (int k = 0; k < 25; k++) begin
      if (k > 0) @(negedge clk);
      chk(tx_valid && tx_bit == w[24-k], "R4 tx bit", {tx_valid, tx_bit}, {1'b1, w[24-k]});
    end
    @(negedge clk);
    chk(!tx_valid, "R4 tx end", tx_valid, 0);
    repeat (3) @(negedge clk);
    lp = 1'b0;
  endtask

  task automatic ser_gaps(input logic [24:0] w, input logic o, input logic [15:0] ed,
                          input logic [1:0] es);
    @(negedge clk);
    odd = o;
    q_data.push_back(ed); q_st.push_back(es); q_tag.push_back("R5 gapped rx");
    for (int k = 0; k < 25; k++) begin
      drv_valid = 1'b1; drv_bit = w[24-k];
      @(negedge clk);
      if (k == 24) chk(rx_done, "R5 done after 25th", rx_done, 1);
      else if (k % 3 == 0) chk(!rx_done, "R5 no early done", rx_done, 0);
      if (k % 4 == 1 && k < 24) begin
        drv_valid = 1'b0; drv_bit = ~w[24-k];
        @(negedge clk);
      end
    end
    drv_valid = 1'b0;
    @(negedge clk);
    chk(!rx_done, "R5 done one cycle", rx_done, 0);
    repeat (2) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [24:0] good, w;
    logic [15:0] d0;
    repeat (3) @(negedge clk);
    // R11
    chk(!tx_valid && !rx_done && !dec_valid && dec_status == 0, "R11 in reset",
        {tx_valid, rx_done, dec_valid, dec_status}, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(!tx_valid && !rx_done && !dec_valid && dec_status == 0, "R11 after reset",
        {tx_valid, rx_done, dec_valid, dec_status}, 0);

    d0   = 16'b0010111101011011;
    good = 25'b0010111110010101011100110;
    @(negedge clk); odd = 1'b0; enc_data = d0; #1;
    chk(enc_cw == good, "R2 worked example R1", enc_cw, good);
    enc_chk(16'h0000, 1'b0, "R1 zero even");
    enc_chk(16'h0000, 1'b1, "R3 zero odd");
    enc_chk(16'hFFFF, 1'b1, "R3 ones odd");
    enc_chk(16'hA5C3, 1'b0, "R2 mixed even");
    enc_chk(16'hA5C3, 1'b1, "R3 mixed odd");
    enc_chk(16'h8001, 1'b1, "R1 corners odd");

    par_dec(good, 1'b0, d0, 2'd0, "R7 clean even");
    par_dec(ref_enc(16'h3C5A, 1'b1), 1'b1, 16'h3C5A, 2'd0, "R7 clean odd");
    par_dec(25'b0010111110010101001100110, 1'b0, d0, 2'd1, "R8 example even");
    par_dec(25'b1101001001111001010101101, 1'b1, 16'b1101000011101010, 2'd1, "R8 example odd");

    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 4; c++) begin
        w = good; w[24-5*r-c] ^= 1'b1;
        par_dec(w, 1'b0, d0, 2'd1, "R8 data cell sweep");
      end
    for (int r = 0; r < 5; r++)
      for (int c = 0; c < 5; c++)
        if (r == 4 || c == 4) begin
          w = ref_enc(16'h96E1, 1'b1); w[24-5*r-c] ^= 1'b1;
          par_dec(w, 1'b1, 16'h96E1, 2'd2, "R9 parity cell sweep");
        end

    w = good; w[24] ^= 1'b1; w[23] ^= 1'b1;
    par_dec(w, 1'b0, strip(w), 2'd3, "R10 same row pair");
    w = good; w[24] ^= 1'b1; w[18] ^= 1'b1;
    par_dec(w, 1'b0, 16'b1010101101011011, 2'd3, "R10 diagonal pair");
    w = good; w[24] ^= 1'b1; w[19] ^= 1'b1;
    par_dec(w, 1'b0, strip(w), 2'd3, "R10 same column pair");

    ser_loop(d0, 1'b0);
    ser_loop(16'h5AF0, 1'b1);
    w = good; w[7] ^= 1'b1;
    ser_gaps(w, 1'b0, d0, 2'd1);
    ser_gaps(ref_enc(16'h0F0F, 1'b1), 1'b1, 16'h0F0F, 2'd0);

    repeat (4) @(negedge clk);
    chk(q_data.size() == 0, "R6 all results seen", q_data.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule